// File: doc/BRIEF.md
# Erasable Byte Memory Behavioural Model

This block is a clocked behavioural model of a byte-wide programmable memory whose cells can only be erased in bulk. The address is 14 bits wide and each word holds 8 bits. Three active-low control inputs (chip select, output gate and program strobe) and two level qualifiers pick one of seven operating modes. One qualifier marks the high programming supply. The other marks the high voltage on address bit 9. Depending on the mode, the block reads the array, verifies stored data, returns an identification byte, applies a program pulse, or keeps its outputs off.

Programming follows the physics of the cell: a pulse can only clear bits, so the stored word becomes the bitwise AND of the old word and the applied data. Only a bulk erase returns bits to 1. The bulk erase input refills the whole array with 0xFF in a single clock, and reset leaves the array in that same erased state. The model does not drive a tri-state bus itself. It presents a drive enable and a data value, and a small external wrapper places them on the shared bus (`bus = dout_en ? dout : 'z`). The program data enters on a separate input that the wrapper takes from the bus.

There is no streaming data path, so no valid/ready handshake is used. Every pin is a plain level, and each program pulse takes effect at the rising clock edge where its conditions hold.

Top module: `uvrom_core`

## Requirements
- R1: The array stores 2^ARRAY_AW words of 8 bits (default ARRAY_AW=11; ARRAY_AW=14 gives the full 16K). A word is selected by the low ARRAY_AW bits of the 14-bit `addr`, so the upper address bits do not change which word is accessed.
- R2: After reset, every word reads 0xFF.
- R3: While `ce_n` is 1, `dout_en` is 0 whatever `oe_n`, `pgm_n`, `vpp_hi` and `id_hv` are, and no word changes (standby and program-inhibit modes).
- R4: Read mode (`ce_n`=0, `oe_n`=0, `pgm_n`=1, `id_hv`=0, `vpp_hi`=0) sets `dout_en`=1 and presents the stored word at `addr` in the same cycle.
- R5: Output-disable mode (`ce_n`=0, `oe_n`=1, `pgm_n`=1) sets `dout_en` to 0.
- R6: At a rising clock edge with `vpp_hi`=1, `ce_n`=0, `oe_n`=1 and `pgm_n`=0, the word at `addr` becomes old AND `din`. Bits can only go from 1 to 0.
- R7: A low `pgm_n` changes no word when `vpp_hi` is 0 or when `oe_n` is 0, and `dout_en` stays 0 in those states.
- R8: Verify mode (`ce_n`=0, `oe_n`=0, `pgm_n`=1, `vpp_hi`=1, `id_hv`=0) sets `dout_en`=1 and presents the stored word.
- R9: Signature mode (`id_hv`=1, `ce_n`=0, `oe_n`=0, `pgm_n`=1) sets `dout_en`=1. It presents 0x20 when `addr` bit 0 is 0 and DEV_CODE (default 0x83) when bit 0 is 1, whatever the other address bits and `vpp_hi` are.
- R10: When `erase_all` is 1 at a rising clock edge, every word reads 0xFF from the next cycle on. A program pulse at the same edge is overridden.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; program pulses and erase act on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; leaves the array erased |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply at its high level |
| id_hv | input | 1 | Address bit 9 held at identification voltage |
| erase_all | input | 1 | Bulk erase request |
| addr | input | 14 | Word address |
| din | input | 8 | Data taken from the bus during a program pulse |
| dout | output | 8 | Data for the bus |
| dout_en | output | 1 | Bus drive enable for the external wrapper |

## Verification
The assertions assume that the control pins and `addr` settle between clock edges and stay steady across each rising edge, and that reset is held for at least one edge before any check counts. They also assume that `erase_all` is only raised outside reset. The bench changes every input just after a falling edge, samples the combinational outputs one nanosecond later, and drops reset only after several edges. This keeps every property inside those assumptions while the bench sweeps every word of the default array size.

// File: rtl/uvrom_pkg.sv
package uvrom_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY   = 3'd0,
    MD_INHIBIT   = 3'd1,
    MD_READ      = 3'd2,
    MD_OUTOFF    = 3'd3,
    MD_PROGRAM   = 3'd4,
    MD_VERIFY    = 3'd5,
    MD_SIGNATURE = 3'd6
  } mode_e;

  localparam logic [7:0] MAKER_CODE = 8'h20;

  function automatic logic mode_drives(input mode_e m);
    return (m == MD_READ) || (m == MD_VERIFY) || (m == MD_SIGNATURE);
  endfunction

endpackage

// File: rtl/uvrom_mode_dec.sv
module uvrom_mode_dec
  import uvrom_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  pgm_n,
  input  logic  vpp_hi,
  input  logic  id_hv,
  output mode_e mode,
  output logic  drive,
  output logic  write
);

  always_comb begin
    if (ce_n) begin
      mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
    end else if (!oe_n && pgm_n) begin
      if (id_hv)       mode = MD_SIGNATURE;
      else if (vpp_hi) mode = MD_VERIFY;
      else             mode = MD_READ;
    end else if (oe_n && !pgm_n && vpp_hi) begin
      mode = MD_PROGRAM;
    end else begin
      mode = MD_OUTOFF;
    end
  end

  assign drive = mode_drives(mode);
  assign write = (mode == MD_PROGRAM);

  // R3
  ce_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!drive && !write));

  // R7
  no_write_lowvpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pgm_n && (!vpp_hi || !oe_n)) |-> (!write && !drive));

  // R5
  outoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && pgm_n) |-> !drive);

endmodule

// File: rtl/uvrom_array.sv
module uvrom_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] BLANK = {DW{1'b1}};

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || erase) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= BLANK;
    end else if (wr) begin
      cells[addr] <= cells[addr] & wdata;
    end
  end

  assign rdata = cells[addr];

  // R6
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !erase) |=> (cells[$past(addr)] == $past(rdata & wdata)));

  // R10
  erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (rdata == BLANK));

endmodule

// File: rtl/uvrom_sig.sv
module uvrom_sig
  import uvrom_pkg::*;
#(
  parameter logic [7:0] DEV_CODE = 8'h83
) (
  input  logic       pick_dev,
  output logic [7:0] code
);

  assign code = pick_dev ? DEV_CODE : MAKER_CODE;

endmodule

// File: rtl/uvrom_core.sv
module uvrom_core
  import uvrom_pkg::*;
#(
  parameter int         ADDR_W   = 14,
  parameter int         ARRAY_AW = 11,
  parameter logic [7:0] DEV_CODE = 8'h83
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic              erase_all,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);

  localparam int USED_AW = (ARRAY_AW < ADDR_W) ? ARRAY_AW : ADDR_W;

  mode_e      mode;
  logic       drive;
  logic       write;
  logic [7:0] word;
  logic [7:0] id_code;

  uvrom_mode_dec u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .pgm_n  (pgm_n),
    .vpp_hi (vpp_hi),
    .id_hv  (id_hv),
    .mode   (mode),
    .drive  (drive),
    .write  (write)
  );

  uvrom_array #(.AW(USED_AW), .DW(8)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .erase (erase_all),
    .wr    (write),
    .addr  (addr[USED_AW-1:0]),
    .wdata (din),
    .rdata (word)
  );

  uvrom_sig #(.DEV_CODE(DEV_CODE)) u_sig (
    .pick_dev (addr[0]),
    .code     (id_code)
  );

  assign dout    = (mode == MD_SIGNATURE) ? id_code : word;
  assign dout_en = drive;

  // R9
  sig_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && pgm_n && id_hv) |->
      (dout_en && dout == (addr[0] ? DEV_CODE : 8'h20)));

  // R4
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && pgm_n && !id_hv) |-> (dout_en && dout == word));

endmodule

// File: tb/uvrom_core_test.sv
module uvrom_core_test;

  localparam int AW = 11;
  localparam int N  = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
  logic        vpp_hi = 1'b0, id_hv = 1'b0, erase_all = 1'b0;
  logic [13:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uvrom_core #(.ADDR_W(14), .ARRAY_AW(AW), .DEV_CODE(8'h83)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .id_hv(id_hv), .erase_all(erase_all), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [7:0] pat_a(input int w);
    return 8'((w * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] pat_b(input int w);
    return 8'(((w * 11) + 90) & 255) ^ 8'hC3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pins(input bit c, input bit o, input bit p, input bit v, input bit h);
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; id_hv = h;
  endtask

  task automatic expect_word(input int a, input bit v, input logic [7:0] exp, input string req);
    @(negedge clk);
    pins(1'b0, 1'b0, 1'b1, v, 1'b0);
    addr = 14'(a);
    #1;
    chk(dout_en === 1'b1 && dout === exp, req, {dout_en, dout}, {1'b1, exp});
  endtask

  task automatic expect_off(input int a, input string req);
    addr = 14'(a);
    #1;
    chk(dout_en === 1'b0, req, dout_en, 0);
  endtask

  task automatic pulse(input int a, input logic [7:0] d, input bit c, input bit o, input bit v);
    @(negedge clk);
    pins(c, o, 1'b0, v, 1'b0);
    addr = 14'(a);
    din = d;
    @(negedge clk);
    pins(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: deselected, all combinations of the other controls keep the bus off
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      pins(1'b1, k[0], k[1], k[2], k[3]);
      expect_off(k * 5, "R3 deselect");
    end

    // R2: erased state after reset
    for (int w = 0; w < N; w++) expect_word(w, 1'b0, 8'hFF, "R2 reset blank");

    // R6: program first pattern
    for (int w = 0; w < N; w++) pulse(w, pat_a(w), 1'b0, 1'b1, 1'b1);
    // R4: read back
    for (int w = 0; w < N; w++) expect_word(w, 1'b0, pat_a(w), "R4 read");

    // R6: second pattern only clears bits
    for (int w = 0; w < N; w++) pulse(w, pat_b(w), 1'b0, 1'b1, 1'b1);
    // R8: verify mode shows the AND
    for (int w = 0; w < N; w++) expect_word(w, 1'b1, pat_a(w) & pat_b(w), "R6 R8 verify and");

    // R1: upper address bits alias onto the same word
    for (int w = 0; w < 64; w++)
      expect_word(w | (5 << AW), 1'b0, pat_a(w) & pat_b(w), "R1 alias");

    // R7: strobe without supply, and strobe with output gate low
    for (int w = 0; w < 32; w++) begin
      pulse(w, 8'h00, 1'b0, 1'b1, 1'b0);
      pulse(w + 32, 8'h00, 1'b0, 1'b0, 1'b1);
    end
    // R7: output stays off while strobe is low without a valid program state
    @(negedge clk);
    pins(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_off(3, "R7 strobe no supply off");
    @(negedge clk);
    pins(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_off(4, "R7 strobe gate low off");
    // R3: strobe while deselected (program inhibit)
    for (int w = 64; w < 96; w++) pulse(w, 8'h00, 1'b1, 1'b1, 1'b1);
    for (int w = 0; w < 96; w++)
      expect_word(w, 1'b0, pat_a(w) & pat_b(w), "R7 R3 no write");

    // R5: output disable
    for (int w = 0; w < 16; w++) begin
      @(negedge clk);
      pins(1'b0, 1'b1, 1'b1, w[0], 1'b0);
      expect_off(w * 97, "R5 output off");
    end

    // R9: signature codes, other bits and supply ignored
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      pins(1'b0, 1'b0, 1'b1, k[1], 1'b1);
      addr = 14'((k * 1234) & 16382) | 14'(k[0]);
      #1;
      chk(dout_en === 1'b1 && dout === (k[0] ? 8'h83 : 8'h20), "R9 signature",
          {dout_en, dout}, {1'b1, (k[0] ? 8'h83 : 8'h20)});
    end

    // R10: erase with a program pulse at the same edge
    @(negedge clk);
    pins(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    addr = 14'd7;
    din = 8'h00;
    erase_all = 1'b1;
    @(negedge clk);
    erase_all = 1'b0;
    pins(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int w = 0; w < N; w++) expect_word(w, 1'b0, 8'hFF, "R10 erased");

    @(negedge clk);
    pins(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule